// File: doc/BRIEF.md
# Priority-Aware Congestion Responder

This block sits beside one switch port and turns a congestion flag from the buffer manager into a flow-control request for the port's MAC. A port in full duplex asks for pause frames. A port in half duplex asks for back-pressure instead. A per-port enable gates both kinds of request. The duplex input is a plain level, so the block works the same whether that level comes from an auto-negotiation result or from a forced setting on a fiber port.

When the strapped auto-off option is set and a high-priority frame reaches a congested port, the block stops requesting flow control for a fixed window. This keeps priority traffic from being throttled by the port's own pause or jam activity. The window is counted in pulses of an external 1 ms enable, and its length is the parameter `WIN_TICKS`, which must lie between 1000 and 2000. Every further high-priority frame that arrives during the window starts the window again from the beginning. When the option is clear, the high-priority input has no effect and requests follow congestion alone.

Top module: `prio_fc_ctrl`

## Requirements
- R1: While `rst` is high, and at the first sampling point after it, `pause_req_o` and `bp_req_o` are both low.
- R2: If `fc_en_i`=1, `cong_i`=1, `full_dup_i`=1 and no suppression is in effect at a clock edge, then from that edge `pause_req_o`=1 and `bp_req_o`=0.
- R3: If `fc_en_i`=1, `cong_i`=1, `full_dup_i`=0 and no suppression is in effect at a clock edge, then from that edge `bp_req_o`=1 and `pause_req_o`=0.
- R4: If `fc_en_i`=0 or `cong_i`=0 at a clock edge, both outputs are low after that edge.
- R5: If `auto_off_en_i`=1, `hi_prio_rx_i`=1 and `cong_i`=1 at a clock edge, suppression starts. Both outputs are low after that same edge, including any request that was already asserted.
- R6: The suppression window closes at the clock edge that samples the `WIN_TICKS`-th high `tick_ms_i` after the last start or restart. A request can reappear at the following edge. Ticks sampled in the same cycle as a start or restart are not counted.
- R7: A high `hi_prio_rx_i` sampled while a window is open (with `auto_off_en_i`=1) restarts the full window, whether or not `cong_i` is high.
- R8: With `auto_off_en_i`=0, `hi_prio_rx_i` has no effect on the outputs, and clearing `auto_off_en_i` ends any open window at that edge.
- R9: `pause_req_o` and `bp_req_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cong_i | input | 1 | Port congested, from the buffer manager |
| full_dup_i | input | 1 | 1 = full duplex, 0 = half duplex (negotiated or forced) |
| fc_en_i | input | 1 | Flow control enabled for this port |
| auto_off_en_i | input | 1 | Suspend flow control on high-priority arrival |
| hi_prio_rx_i | input | 1 | One-cycle pulse per received high-priority frame |
| tick_ms_i | input | 1 | 1 ms enable pulse, one cycle wide |
| pause_req_o | output | 1 | Request pause frames from the MAC (registered) |
| bp_req_o | output | 1 | Request back-pressure from the MAC (registered) |

## Verification
The assertions only look at the ports. They assume that every input is a clean level at each sampling edge, and that `hi_prio_rx_i` and `tick_ms_i` are sampled independently of each other with no ordering between them. They do not assume anything about how far apart ticks are, so the bench drives ticks much faster than one per millisecond and still covers the full default window. The random phase holds its inputs steady for many cycles and fires high-priority pulses only rarely, so that windows can run to expiry. Directed sequences then place the closing tick and a restart exactly at the boundary.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic {
    DUPLEX_HALF = 1'b0,
    DUPLEX_FULL = 1'b1
  } duplex_e;

  typedef struct packed {
    logic pause;
    logic bp;
  } fc_req_t;
endpackage

// File: rtl/fc_suppress_timer.sv
module fc_suppress_timer #(
  parameter int WIN_TICKS = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic auto_off_en_i,
  input  logic hi_prio_i,
  input  logic cong_i,
  input  logic tick_i,
  output logic suppress_o
);
  localparam int CW = $clog2(WIN_TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(WIN_TICKS);
  localparam logic [CW-1:0] LAST = CW'(1);

  logic          active_q;
  logic [CW-1:0] left_q;
  logic          start;

  // a start needs congestion; a restart only needs an open window
  assign start      = auto_off_en_i & hi_prio_i & (cong_i | active_q);
  assign suppress_o = auto_off_en_i & (active_q | start);

  always_ff @(posedge clk) begin
    if (rst || !auto_off_en_i) begin
      active_q <= 1'b0;
      left_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      left_q   <= LOAD;
    end else if (active_q && tick_i) begin
      if (left_q == LAST) begin
        active_q <= 1'b0;
        left_q   <= '0;
      end else begin
        left_q <= left_q - LAST;
      end
    end
  end
endmodule

// File: rtl/fc_request_gen.sv
module fc_request_gen
  import fc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    fc_en_i,
  input  logic    cong_i,
  input  duplex_e duplex_i,
  input  logic    suppress_i,
  output fc_req_t req_o
);
  logic    want;
  fc_req_t req_d;

  assign want = fc_en_i & cong_i & ~suppress_i;

  always_comb begin
    req_d.pause = want & (duplex_i == DUPLEX_FULL);
    req_d.bp    = want & (duplex_i == DUPLEX_HALF);
  end

  always_ff @(posedge clk) begin
    if (rst) req_o <= '0;
    else     req_o <= req_d;
  end
endmodule

// File: rtl/prio_fc_ctrl.sv
module prio_fc_ctrl
  import fc_pkg::*;
#(
  parameter int WIN_TICKS = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic cong_i,
  input  logic full_dup_i,
  input  logic fc_en_i,
  input  logic auto_off_en_i,
  input  logic hi_prio_rx_i,
  input  logic tick_ms_i,
  output logic pause_req_o,
  output logic bp_req_o
);
  logic    suppress;
  fc_req_t req;

  fc_suppress_timer #(.WIN_TICKS(WIN_TICKS)) timer_i (
    .clk           (clk),
    .rst           (rst),
    .auto_off_en_i (auto_off_en_i),
    .hi_prio_i     (hi_prio_rx_i),
    .cong_i        (cong_i),
    .tick_i        (tick_ms_i),
    .suppress_o    (suppress)
  );

  fc_request_gen reqgen_i (
    .clk        (clk),
    .rst        (rst),
    .fc_en_i    (fc_en_i),
    .cong_i     (cong_i),
    .duplex_i   (duplex_e'(full_dup_i)),
    .suppress_i (suppress),
    .req_o      (req)
  );

  assign pause_req_o = req.pause;
  assign bp_req_o    = req.bp;
endmodule

// File: rtl/prio_fc_ctrl_chk.sv
module prio_fc_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic cong_i,
  input logic full_dup_i,
  input logic fc_en_i,
  input logic auto_off_en_i,
  input logic hi_prio_rx_i,
  input logic pause_req_o,
  input logic bp_req_o
);
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(pause_req_o && bp_req_o));

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (!fc_en_i || !cong_i) |=> (!pause_req_o && !bp_req_o));

  assert_start_drops_R5: assert property (@(posedge clk) disable iff (rst)
    (auto_off_en_i && hi_prio_rx_i && cong_i) |=> (!pause_req_o && !bp_req_o));

  assert_full_pause_R2: assert property (@(posedge clk) disable iff (rst)
    (fc_en_i && cong_i && full_dup_i && !auto_off_en_i) |=> (pause_req_o && !bp_req_o));

  assert_half_bp_R3: assert property (@(posedge clk) disable iff (rst)
    (fc_en_i && cong_i && !full_dup_i && !auto_off_en_i) |=> (bp_req_o && !pause_req_o));

  assert_pause_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pause_req_o) |-> $past(fc_en_i && cong_i && full_dup_i));

  assert_bp_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(bp_req_o) |-> $past(fc_en_i && cong_i && !full_dup_i));
endmodule

bind prio_fc_ctrl prio_fc_ctrl_chk chk_i (
  .clk           (clk),
  .rst           (rst),
  .cong_i        (cong_i),
  .full_dup_i    (full_dup_i),
  .fc_en_i       (fc_en_i),
  .auto_off_en_i (auto_off_en_i),
  .hi_prio_rx_i  (hi_prio_rx_i),
  .pause_req_o   (pause_req_o),
  .bp_req_o      (bp_req_o)
);

// File: tb/prio_fc_ctrl_tb_top.sv
module prio_fc_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 1500;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cong = 1'b0, full = 1'b0, fc_en = 1'b0, ae = 1'b0, hp = 1'b0, tick = 1'b0;
  logic pause_req, bp_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bench model state
  logic m_act = 1'b0;
  int   m_left = 0;
  logic m_pause = 1'b0, m_bp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_fc_ctrl #(.WIN_TICKS(W)) dut_i (
    .clk (clk), .rst (rst), .cong_i (cong), .full_dup_i (full),
    .fc_en_i (fc_en), .auto_off_en_i (ae), .hi_prio_rx_i (hp),
    .tick_ms_i (tick), .pause_req_o (pause_req), .bp_req_o (bp_req)
  );

  function automatic logic exp_supp(logic a, logic h, logic c, logic act);
    return a & (act | (h & (c | act)));
  endfunction

  task automatic check(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  // advance one edge with the current inputs, update the model, compare
  task automatic step(string tag);
    logic supp, want, start;
    supp  = exp_supp(ae, hp, cong, m_act);
    start = ae & hp & (cong | m_act);
    want  = fc_en & cong & ~supp;
    if (rst) begin
      m_pause = 1'b0; m_bp = 1'b0; m_act = 1'b0; m_left = 0;
    end else begin
      m_pause = want & full;
      m_bp    = want & ~full;
      if (!ae) begin
        m_act = 1'b0; m_left = 0;
      end else if (start) begin
        m_act = 1'b1; m_left = W;
      end else if (m_act && tick) begin
        if (m_left == 1) begin m_act = 1'b0; m_left = 0; end
        else m_left = m_left - 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    cycles++;
    check({tag, " pause"}, pause_req, m_pause);
    check({tag, " bp"}, bp_req, m_bp);
    check("R9 exclusive", pause_req & bp_req, 1'b0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240517));
    @(negedge clk);
    rst = 1'b1; cong = 1'b1; fc_en = 1'b1; full = 1'b1;
    step("R1 in reset");
    step("R1 in reset");
    rst = 1'b0; cong = 1'b0;
    step("R1 after reset");

    // R2 full duplex pause
    cong = 1'b1; full = 1'b1; ae = 1'b0;
    step("R2 pause");
    check("R2 directed pause", pause_req, 1'b1);
    // R3 half duplex back-pressure
    full = 1'b0;
    step("R3 bp");
    check("R3 directed bp", bp_req, 1'b1);
    // R4 disable
    fc_en = 1'b0;
    step("R4 disabled");
    check("R4 directed quiet", bp_req | pause_req, 1'b0);
    fc_en = 1'b1; cong = 1'b0;
    step("R4 no congestion");
    // R8 hi prio ignored when auto-off clear
    cong = 1'b1; full = 1'b1; hp = 1'b1;
    step("R8 ignored");
    check("R8 directed pause stays", pause_req, 1'b1);
    hp = 1'b0;
    step("R2 steady");

    // R5 start drops an asserted request at the next edge
    ae = 1'b1; hp = 1'b1;
    step("R5 start");
    check("R5 directed drop", pause_req, 1'b0);
    hp = 1'b0; tick = 1'b1;
    for (int i = 1; i < W; i++) step("R6 window open");
    check("R6 still suppressed at W-1", pause_req, 1'b0);
    step("R6 closing tick");
    check("R6 suppressed at closing edge", pause_req, 1'b0);
    tick = 1'b0;
    step("R6 resume");
    check("R6 directed resume", pause_req, 1'b1);

    // R7 restart without congestion
    hp = 1'b1;
    step("R5 second start");
    hp = 1'b0; tick = 1'b1;
    for (int i = 0; i < W/2; i++) step("R7 pre restart");
    cong = 1'b0; hp = 1'b1;
    step("R7 restart");
    hp = 1'b0; cong = 1'b1;
    for (int i = 1; i < W; i++) step("R7 after restart");
    check("R7 directed restarted window", pause_req, 1'b0);
    step("R7 closing");
    tick = 1'b0;
    step("R7 resume");
    check("R7 directed resume", pause_req, 1'b1);

    // R8 clearing auto-off ends the window
    hp = 1'b1; full = 1'b0;
    step("R5 third start");
    hp = 1'b0; ae = 1'b0;
    step("R8 window cleared");
    check("R8 directed bp back", bp_req, 1'b1);

    // random phase
    for (int n = 0; n < 40000; n++) begin
      if ($urandom % 300 == 0) full  = $urandom % 2;
      if ($urandom % 500 == 0) fc_en = ($urandom % 5) != 0;
      if ($urandom % 2000 == 0) ae   = ($urandom % 4) != 0;
      if ($urandom % 40 == 0)  cong  = ($urandom % 5) != 0;
      hp   = ($urandom % 900) == 0;
      tick = ($urandom % 3) != 0;
      step("R2 R3 R4 R5 R6 R7 R8 random");
    end
    finish_run();
  end
endmodule